// File: doc/BRIEF.md
# Timer Clock Source Selector

This block turns one of eight count sources into a single-cycle count-enable strobe for a downstream timer counter. A 3-bit select code picks the source. The choices are: stopped, every system clock, four divided rates taken from one shared free-running prescaler, and edges on an asynchronous external pin. The pin can be counted on either its falling or its rising transitions.

The pin is sampled by its level only. Its direction does not matter, so transitions that the chip drives onto the pin are still counted. This lets software step the timer by toggling the pin. A prescaler clear input restarts the shared divider, so the next divided strobe arrives one full period after the clear. The strobe is registered. A new select code takes effect on the next clock edge.

Top module: `tmr_clk_src_sel`

## Requirements
- R1: Select code 3'b000 produces no strobe on `cnt_en_o`, so the timer is stopped.
- R2: Select code 3'b001 makes `cnt_en_o` high on the clock edge that follows every cycle in which the code is applied.
- R3: Select codes 3'b010, 3'b011, 3'b100 and 3'b101 give one strobe every 8, 64, 256 and 1024 system clocks. Each tap fires when the low 3, 6, 8 or 10 bits of a shared 10-bit free-running counter are all ones. Two divided strobes never occur in consecutive cycles.
- R4: Select code 3'b110 gives one strobe for each falling transition of `ext_pin_i`.
- R5: Select code 3'b111 gives one strobe for each rising transition of `ext_pin_i`. Only the pin level is used, whatever drives it.
- R6: For a pin transition set up before clock edge E1, the strobe is high only after edge E3 (two synchronizer flops plus the output register). It lasts exactly one cycle.
- R7: With `presc_clr_i` high at edge E0 and a divide-by-8 code held, `cnt_en_o` stays low after edges E1 to E7 and goes high after E8.
- R8: A change of select code controls the strobe starting with the next clock edge.
- R9: While `rst_ni` is low, `cnt_en_o` is low. Reset clears the prescaler, so with code 3'b101 held through reset, the first strobe appears after the 1024th clock edge following release, and none appears before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_i | input | 3 | Count source select code |
| presc_clr_i | input | 1 | Clears the shared prescaler counter |
| ext_pin_i | input | 1 | Asynchronous external count pin (level sampled) |
| cnt_en_o | output | 1 | Single-cycle count-enable strobe |

## Verification
The bench measures the exact number of pipeline edges between a pin transition and its strobe. A design with a missing or extra synchronizer stage would put the strobe one cycle early or late, and a wrong edge polarity would fire on the opposite transition. After a prescaler clear, the bench counts edges to the next divided strobe, which exposes a clear that leaves low bits behind or is ignored. It also counts strobes over windows of exact multiples of each period, so a wrong tap width shows up as a wrong count. Strobes after reset release are counted in the same way, which catches a prescaler that reset leaves uncleared. Finally, the bench samples the strobe on the first edge after a select change, which catches a select path that lags by an extra register.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   localparam int unsigned TCS_N_TAPS = 4;

   typedef enum logic [2:0] {
      SRC_OFF      = 3'b000,
      SRC_SYS      = 3'b001,
      SRC_DIV_A    = 3'b010,
      SRC_DIV_B    = 3'b011,
      SRC_DIV_C    = 3'b100,
      SRC_DIV_D    = 3'b101,
      SRC_PIN_FALL = 3'b110,
      SRC_PIN_RISE = 3'b111
   } tcs_src_e;

   function automatic logic tcs_is_div(input logic [2:0] code);
      return (code >= 3'b010) && (code <= 3'b101);
   endfunction

   function automatic logic tcs_is_pin(input logic [2:0] code);
      return code[2] & code[1];
   endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
   parameter int unsigned CNT_W  = 10,
   parameter int unsigned N_TAPS = 4,
   parameter int unsigned TAP_EXP [N_TAPS] = '{3, 6, 8, 10}
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   output logic [N_TAPS-1:0] tap_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
      if (TAP_EXP[g] < 1 || TAP_EXP[g] > CNT_W) begin : g_bad
         $error("tcs_prescaler: tap exponent out of counter range");
      end
      if (g > 0) begin : g_order
         if (TAP_EXP[g] <= TAP_EXP[g-1]) begin : g_bad_order
            $error("tcs_prescaler: tap exponents must increase");
         end
      end
      localparam logic [CNT_W-1:0] MASK = CNT_W'((64'd1 << TAP_EXP[g]) - 64'd1);
      assign tap_o[g] = ((cnt_q & MASK) == MASK);
   end

endmodule

// File: rtl/tcs_pin_edge.sv
module tcs_pin_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tcs_pin_edge: at least two synchronizer stages required");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         last_q <= 1'b0;
      end else begin
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise_o =  sync_q[SYNC_STAGES-1] & ~last_q;
   assign fall_o = ~sync_q[SYNC_STAGES-1] &  last_q;

endmodule

// File: rtl/tmr_clk_src_sel.sv
module tmr_clk_src_sel #(
   parameter int unsigned PRESC_W     = 10,
   parameter int unsigned DIV_A_EXP   = 3,
   parameter int unsigned DIV_B_EXP   = 6,
   parameter int unsigned DIV_C_EXP   = 8,
   parameter int unsigned DIV_D_EXP   = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] sel_i,
   input  logic       presc_clr_i,
   input  logic       ext_pin_i,
   output logic       cnt_en_o
);

   import tcs_pkg::*;

   localparam int unsigned N_TAPS = TCS_N_TAPS;
   localparam int unsigned TAP_EXP [N_TAPS] = '{DIV_A_EXP, DIV_B_EXP, DIV_C_EXP, DIV_D_EXP};

   if (PRESC_W < DIV_D_EXP) begin : g_bad_width
      $error("tmr_clk_src_sel: prescaler too narrow for the slowest tap");
   end

   logic [N_TAPS-1:0] tap;
   logic              pin_rise;
   logic              pin_fall;
   logic              tick_d;
   logic              cnt_en_q;

   tcs_prescaler #(
      .CNT_W  (PRESC_W),
      .N_TAPS (N_TAPS),
      .TAP_EXP(TAP_EXP)
   ) presc_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (presc_clr_i),
      .tap_o (tap)
   );

   tcs_pin_edge #(
      .SYNC_STAGES(SYNC_STAGES)
   ) pin_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (ext_pin_i),
      .rise_o(pin_rise),
      .fall_o(pin_fall)
   );

   always_comb begin
      unique case (tcs_src_e'(sel_i))
         SRC_OFF:      tick_d = 1'b0;
         SRC_SYS:      tick_d = 1'b1;
         SRC_DIV_A:    tick_d = tap[0];
         SRC_DIV_B:    tick_d = tap[1];
         SRC_DIV_C:    tick_d = tap[2];
         SRC_DIV_D:    tick_d = tap[3];
         SRC_PIN_FALL: tick_d = pin_fall;
         SRC_PIN_RISE: tick_d = pin_rise;
         default:      tick_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_en_q <= 1'b0;
      end else begin
         cnt_en_q <= tick_d;
      end
   end

   assign cnt_en_o = cnt_en_q;

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [2:0] sel_i,
   input logic       presc_clr_i,
   input logic       cnt_en_o
);

   import tcs_pkg::*;

   a_r1_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'b000) |=> !cnt_en_o);

   a_r2_sys_every: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'b001) |=> cnt_en_o);

   a_r3_div_sparse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_en_o && tcs_is_div(sel_i) && tcs_is_div($past(sel_i))) |=> !cnt_en_o);

   a_r6_pin_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_en_o && tcs_is_pin(sel_i) && tcs_is_pin($past(sel_i))) |=> !cnt_en_o);

   a_r7_clr_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (presc_clr_i && tcs_is_div(sel_i)) ##1 tcs_is_div(sel_i) |=> !cnt_en_o);

endmodule

bind tmr_clk_src_sel tcs_checker chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .sel_i      (sel_i),
   .presc_clr_i(presc_clr_i),
   .cnt_en_o   (cnt_en_o)
);

// File: tb/tmr_clk_src_sel_tb_top.sv
`timescale 1ns/1ps
module tmr_clk_src_sel_tb_top;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [2:0] sel_i = 3'b000;
   logic       presc_clr_i = 1'b0;
   logic       ext_pin_i = 1'b0;
   logic       cnt_en_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk_i = ~clk_i;

   tmr_clk_src_sel dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (sel_i),
      .presc_clr_i(presc_clr_i),
      .ext_pin_i  (ext_pin_i),
      .cnt_en_o   (cnt_en_o)
   );

   localparam int NV = 8;
   localparam logic [2:0] V_SEL [NV] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};
   localparam int         V_CYC [NV] = '{100, 40, 64, 128, 512, 2048, 20, 20};
   localparam int         V_EXP [NV] = '{0, 40, 8, 2, 2, 2, 0, 0};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_win(input int n, output int c);
      c = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk_i);
         if (cnt_en_o) c++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk_i);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int c;
      // R9: reset holds the strobe low, prescaler starts from zero
      sel_i = 3'b101;
      repeat (5) @(negedge clk_i);
      check(cnt_en_o == 1'b0, "R9 reset low", cnt_en_o, 0);
      rst_ni = 1'b1;
      count_win(1023, c);
      check(c == 0, "R9 no early strobe after reset", c, 0);
      @(negedge clk_i);
      check(cnt_en_o == 1'b1, "R9 first /1024 strobe", cnt_en_o, 1);

      // table walk: R1 R2 R3, plus pin codes with an idle pin
      for (int v = 0; v < NV; v++) begin
         @(negedge clk_i);
         sel_i = V_SEL[v];
         presc_clr_i = 1'b1;
         @(negedge clk_i);
         presc_clr_i = 1'b0;
         count_win(V_CYC[v], c);
         check(c == V_EXP[v], $sformatf("R1/R2/R3 code %0d count", V_SEL[v]), c, V_EXP[v]);
      end

      // R8: select change acts on the next edge
      @(negedge clk_i); sel_i = 3'b001;
      repeat (3) @(negedge clk_i);
      check(cnt_en_o == 1'b1, "R8 before change", cnt_en_o, 1);
      sel_i = 3'b000;
      @(negedge clk_i);
      check(cnt_en_o == 1'b0, "R8 after change to stop", cnt_en_o, 0);
      sel_i = 3'b001;
      @(negedge clk_i);
      check(cnt_en_o == 1'b1, "R8 after change to sys", cnt_en_o, 1);

      // R5 R6: rising edge latency and width
      sel_i = 3'b111; ext_pin_i = 1'b0;
      repeat (5) @(negedge clk_i);
      ext_pin_i = 1'b1;
      count_win(2, c);
      check(c == 0, "R6 rise not early", c, 0);
      @(negedge clk_i);
      check(cnt_en_o == 1'b1, "R5 rise strobe after third edge", cnt_en_o, 1);
      @(negedge clk_i);
      check(cnt_en_o == 1'b0, "R6 rise strobe one cycle", cnt_en_o, 0);

      // R4 R6: falling edge latency
      sel_i = 3'b110;
      repeat (5) @(negedge clk_i);
      ext_pin_i = 1'b0;
      count_win(2, c);
      check(c == 0, "R6 fall not early", c, 0);
      @(negedge clk_i);
      check(cnt_en_o == 1'b1, "R4 fall strobe after third edge", cnt_en_o, 1);
      @(negedge clk_i);
      check(cnt_en_o == 1'b0, "R6 fall strobe one cycle", cnt_en_o, 0);

      // R4 R5: burst counts, one strobe per qualifying transition
      for (int m = 0; m < 2; m++) begin
         sel_i = (m == 0) ? 3'b110 : 3'b111;
         repeat (5) @(negedge clk_i);
         c = 0;
         for (int p = 0; p < 5; p++) begin
            ext_pin_i = 1'b1;
            repeat (3) begin @(negedge clk_i); if (cnt_en_o) c++; end
            ext_pin_i = 1'b0;
            repeat (3) begin @(negedge clk_i); if (cnt_en_o) c++; end
         end
         repeat (5) begin @(negedge clk_i); if (cnt_en_o) c++; end
         check(c == 5, (m == 0) ? "R4 falling burst count" : "R5 rising burst count", c, 5);
      end

      // R7: prescaler clear restarts the /8 period
      sel_i = 3'b010;
      repeat (13) @(negedge clk_i);
      presc_clr_i = 1'b1;
      @(negedge clk_i);
      presc_clr_i = 1'b0;
      count_win(7, c);
      check(c == 0, "R7 no strobe before full period", c, 0);
      @(negedge clk_i);
      check(cnt_en_o == 1'b1, "R7 strobe one period after clear", cnt_en_o, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule